// File: doc/BRIEF.md
# Soft-Reset and Clock-Gate Controller

This block owns one 32-bit control register for a peripheral core. Bit 31 requests soft reset and bit 30 gates the core clock. Software reaches the register through a simple register-bus slave port at three word aliases. The first alias replaces the whole register. The second ORs the written value in. The third clears every bit written as 1. A read from any alias returns the current register value.

Setting the soft-reset bit drives the core reset output at once. The block then holds that reset for a programmable number of cycles before it sets the gate bit by itself, which stops the core clock enable. Software polls the gate bit to learn that reset has taken hold. To leave reset, software clears soft reset, waits at least 1 µs, and then clears the gate bit, which brings the clock enable back. The register lives outside the reset domain it controls, so soft reset never clears it. Only the bus-side reset input does.

Top module: `rstgate_top`

## Requirements
- R1: After the bus-side reset input `rstN` is released, the register is 0, `coreReset` is 0, `coreClkEn` is 1 and `busRData` is 0.
- R2: A write with `busAddr[3:2]` = 0 replaces all 32 register bits with `busWData`. `busAddr[1:0]` are ignored.
- R3: A write with `busAddr[3:2]` = 1 ORs `busWData` into the register.
- R4: A write with `busAddr[3:2]` = 2 clears every register bit that is 1 in `busWData` and leaves the other bits alone.
- R5: A write with `busAddr[3:2]` = 3 changes nothing. A read there returns 0.
- R6: A read with `busAddr[3:2]` in 0..2 returns the register value as it stood before that clock edge. The value appears on `busRData` one cycle after `busRdEn` and holds until the next read.
- R7: `coreReset` equals register bit 31 and follows a write from the cycle after that write.
- R8: `coreClkEn` is the inverse of register bit 30.
- R9: When bit 31 goes from 0 to 1, the block sets bit 30 by itself exactly `HOLD_CYCLES` cycles later, as long as bit 31 stays 1 that long. If bit 31 is cleared earlier, the hold count restarts and bit 30 is not set.
- R10: In the full entry and exit sequence, `coreReset` rises before `coreClkEn` falls. `coreClkEn` stays low after reset is released and rises only when bit 30 is cleared.
- R11: The block sets bit 30 only once per soft-reset entry. If software clears bit 30 while bit 31 is still 1, it stays clear.
- R12: If the block's own gate set and a software write that clears bit 30 fall on the same edge, bit 30 ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and control clock |
| rstN | input | 1 | Asynchronous active-low reset of the register block |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busRdEn | input | 1 | Read strobe, one cycle per read |
| busAddr | input | ADDR_W | Byte address; bits 3:2 select the alias |
| busWData | input | 32 | Write data |
| busRData | output | 32 | Registered read data |
| coreReset | output | 1 | Active-high reset into the peripheral core |
| coreClkEn | output | 1 | Enable for the external core clock-gating cell |

## Verification
Register writes and the outputs `coreReset` and `coreClkEn` take effect at the edge that samples the write. Read data is due one edge after `busRdEn`. The automatic gate set lands `HOLD_CYCLES` edges after the edge that stored bit 31. The bench drives every operation for exactly one edge and steps a cycle-accurate reference model at that same edge. It compares all three outputs at the following falling edge, so each result is checked in the cycle it is due. The directed sequences count edges from the soft-reset write to the fall of the clock enable. They also place a gate-clearing write on the very edge of the automatic set.

// File: rtl/rstgate_pkg.sv
package rstgate_pkg;

  localparam int REG_W    = 32;
  localparam int SRST_BIT = 31;
  localparam int GATE_BIT = 30;

  // Word alias selected by address bits 3:2
  typedef enum logic [1:0] {
    SEL_PLAIN = 2'd0,
    SEL_SET   = 2'd1,
    SEL_CLR   = 2'd2,
    SEL_NONE  = 2'd3
  } regSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrPlain;
    logic wrSet;
    logic wrClr;
    logic rdHit;
    logic rdMiss;
    logic hwGateSet;
  } ctrlStrobe_t;

endpackage

// File: rtl/rstgate_ctrl.sv
module rstgate_ctrl
  import rstgate_pkg::*;
#(
  parameter int HOLD_CYCLES = 8,
  parameter int ADDR_W      = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              softResetQ,
  output ctrlStrobe_t       strobe
);

  localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(HOLD_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_CYCLES - 1);

  logic              upperZero;
  logic [CNT_W-1:0]  holdCnt;
  regSel_e           sel;
  logic              mapped;

  generate
    if (ADDR_W > 4) begin : g_upper
      assign upperZero = (busAddr[ADDR_W-1:4] == '0);
    end else begin : g_noUpper
      assign upperZero = 1'b1;
    end
  endgenerate

  assign sel    = regSel_e'(busAddr[3:2]);
  assign mapped = upperZero && (sel != SEL_NONE);

  // Hold counter: counts edges while soft reset is held, saturates
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt <= '0;
    end else if (!softResetQ) begin
      holdCnt <= '0;
    end else if (holdCnt != CNT_MAX) begin
      holdCnt <= holdCnt + 1'b1;
    end
  end

  always_comb begin
    strobe           = '0;
    strobe.wrPlain   = busWrEn && mapped && (sel == SEL_PLAIN);
    strobe.wrSet     = busWrEn && mapped && (sel == SEL_SET);
    strobe.wrClr     = busWrEn && mapped && (sel == SEL_CLR);
    strobe.rdHit     = busRdEn && mapped;
    strobe.rdMiss    = busRdEn && !mapped;
    strobe.hwGateSet = softResetQ && (holdCnt == CNT_LAST);
  end

endmodule

// File: rtl/rstgate_dp.sv
module rstgate_dp
  import rstgate_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [REG_W-1:0]  busWData,
  output logic [REG_W-1:0]  ctrlQ,
  output logic [REG_W-1:0]  busRData
);

  logic [REG_W-1:0] nextVal;

  always_comb begin
    nextVal = ctrlQ;
    if (strobe.wrPlain) nextVal = busWData;
    if (strobe.wrSet)   nextVal = ctrlQ | busWData;
    if (strobe.wrClr)   nextVal = ctrlQ & ~busWData;
    // Hardware gate set overrides a simultaneous software clear
    if (strobe.hwGateSet) nextVal[GATE_BIT] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ    <= '0;
      busRData <= '0;
    end else begin
      ctrlQ <= nextVal;
      if (strobe.rdHit) begin
        busRData <= ctrlQ;
      end else if (strobe.rdMiss) begin
        busRData <= '0;
      end
    end
  end

endmodule

// File: rtl/rstgate_top.sv
module rstgate_top
  import rstgate_pkg::*;
#(
  parameter int HOLD_CYCLES = 8,
  parameter int ADDR_W      = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWData,
  output logic [31:0]       busRData,
  output logic              coreReset,
  output logic              coreClkEn
);

  ctrlStrobe_t      strobe;
  logic [REG_W-1:0] ctrlQ;

  rstgate_ctrl #(
    .HOLD_CYCLES (HOLD_CYCLES),
    .ADDR_W      (ADDR_W)
  ) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .busWrEn    (busWrEn),
    .busRdEn    (busRdEn),
    .busAddr    (busAddr),
    .softResetQ (ctrlQ[SRST_BIT]),
    .strobe     (strobe)
  );

  rstgate_dp dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .busWData (busWData),
    .ctrlQ    (ctrlQ),
    .busRData (busRData)
  );

  assign coreReset = ctrlQ[SRST_BIT];
  assign coreClkEn = ~ctrlQ[GATE_BIT];

endmodule

// File: rtl/rstgate_chk.sv
module rstgate_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWrEn,
  input logic              busRdEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busWData,
  input logic [31:0]       busRData,
  input logic              coreReset,
  input logic              coreClkEn
);

  // R3 R7
  set_srst_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_W'(4) && busWData[31]) |=> coreReset);

  // R4 R8
  clr_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_W'(8) && busWData[30] && !coreReset) |=> coreClkEn);

  // R5
  unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_W'(12) && !coreReset)
      |=> ($stable(coreReset) && $stable(coreClkEn)));

  // R5 R6
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr == ADDR_W'(12)) |=> (busRData == 32'h0));

  // R9 R10
  gate_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(coreClkEn) && !$past(busWrEn)) |-> $past(coreReset));

endmodule

bind rstgate_top rstgate_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .busWrEn   (busWrEn),
  .busRdEn   (busRdEn),
  .busAddr   (busAddr),
  .busWData  (busWData),
  .busRData  (busRData),
  .coreReset (coreReset),
  .coreClkEn (coreClkEn)
);

// File: tb/rstgate_top_tb_top.sv
module rstgate_top_tb_top;

  localparam int HOLD = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWData = '0;
  logic [31:0] busRData;
  logic        coreReset;
  logic        coreClkEn;

  int nChecks = 0;
  int nFails  = 0;
  int cyc     = 0;

  logic [31:0] mReg = '0;
  logic [31:0] mRd  = '0;
  int          mCnt = 0;

  always #5 clk = ~clk;

  rstgate_top #(.HOLD_CYCLES(HOLD), .ADDR_W(4)) dut_i (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWData(busWData), .busRData(busRData),
    .coreReset(coreReset), .coreClkEn(coreClkEn)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [31:0] applyWrite(input logic [31:0] cur, input logic [1:0] sel,
                                             input logic [31:0] d);
    case (sel)
      2'd0:    return d;
      2'd1:    return cur | d;
      2'd2:    return cur & ~d;
      default: return cur;
    endcase
  endfunction

  task automatic modelEdge(input logic wr, input logic rd, input logic [3:0] a, input logic [31:0] d);
    logic [31:0] nv;
    nv = wr ? applyWrite(mReg, a[3:2], d) : mReg;
    if (mReg[31] && mCnt == HOLD - 1) nv[30] = 1'b1;
    if (rd) mRd = (a[3:2] == 2'd3) ? 32'h0 : mReg;
    mCnt = !mReg[31] ? 0 : ((mCnt == HOLD) ? HOLD : mCnt + 1);
    mReg = nv;
  endtask

  task automatic step(input logic wr, input logic rd, input logic [3:0] a,
                      input logic [31:0] d, input string req);
    busWrEn = wr; busRdEn = rd; busAddr = a; busWData = d;
    @(posedge clk);
    cyc++;
    modelEdge(wr, rd, a, d);
    @(negedge clk);
    busWrEn = 1'b0; busRdEn = 1'b0;
    check({req, " R7 coreReset"}, 32'(coreReset), 32'(mReg[31]));
    check({req, " R8 coreClkEn"}, 32'(coreClkEn), 32'(!mReg[30]));
    check({req, " R6 busRData"}, busRData, mRd);
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 4'h0, 32'h0, req);
  endtask

  task automatic cleanAll();
    step(1'b1, 1'b0, 4'h0, 32'h0, "R2 clean");
    step(1'b1, 1'b0, 4'h0, 32'h0, "R2 clean");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    int rstCyc;
    int fallCyc;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 coreReset", 32'(coreReset), 32'h0);
    check("R1 coreClkEn", 32'(coreClkEn), 32'h1);
    check("R1 busRData", busRData, 32'h0);
    step(1'b0, 1'b1, 4'h0, 32'h0, "R1 read");
    check("R1 register", busRData, 32'h0);

    // R2 R3 R4 directed on low field bits
    step(1'b1, 1'b0, 4'h1, 32'h1234_5678, "R2 plain");
    step(1'b0, 1'b1, 4'h0, 32'h0, "R2 read");
    check("R2 plain value", busRData, 32'h1234_5678);
    step(1'b1, 1'b0, 4'h6, 32'h0000_0F00, "R3 set");
    step(1'b0, 1'b1, 4'h4, 32'h0, "R3 read");
    check("R3 set value", busRData, 32'h1234_5F78);
    step(1'b1, 1'b0, 4'h8, 32'h0000_00FF, "R4 clr");
    step(1'b0, 1'b1, 4'h8, 32'h0, "R4 read");
    check("R4 clr value", busRData, 32'h1234_5F00);
    step(1'b1, 1'b0, 4'hC, 32'hFFFF_FFFF, "R5 unmapped wr");
    step(1'b0, 1'b1, 4'hD, 32'h0, "R5 unmapped rd");
    check("R5 unmapped read", busRData, 32'h0);
    step(1'b0, 1'b1, 4'h0, 32'h0, "R5 read");
    check("R5 register untouched", busRData, 32'h1234_5F00);

    // Random mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] d;
      logic [3:0]  a;
      d = $urandom;
      if ($urandom_range(3) != 0) d[31:30] = 2'b00;
      a = 4'($urandom_range(15));
      case ($urandom_range(3))
        0:       step(1'b1, 1'b0, a, d, "R2-4 random wr");
        1:       step(1'b0, 1'b1, a, d, "R6 random rd");
        2:       step(1'b1, 1'b1, a, d, "R6 random wr+rd");
        default: step(1'b0, 1'b0, a, d, "R9 random idle");
      endcase
    end
    cleanAll();

    // R10 full entry and exit sequence
    step(1'b1, 1'b0, 4'h8, 32'hC000_0000, "R10 prep");
    step(1'b1, 1'b0, 4'h4, 32'h8000_0000, "R10 enter");
    rstCyc = cyc;
    fallCyc = -1;
    check("R10 reset before gate", 32'(coreClkEn), 32'h1);
    for (int i = 0; i < HOLD + 4; i++) begin
      step(1'b0, 1'b1, 4'h0, 32'h0, "R10 poll");
      if (!coreClkEn && fallCyc < 0) begin
        fallCyc = cyc;
        check("R10 reset held at gate", 32'(coreReset), 32'h1);
      end
    end
    check("R9 gate delay", 32'(fallCyc - rstCyc), 32'(HOLD));
    check("R9 gate readback", 32'(busRData[30]), 32'h1);
    step(1'b1, 1'b0, 4'h8, 32'h8000_0000, "R10 release");
    idle(100, "R10 wait 1us");
    check("R10 clock still gated", 32'(coreClkEn), 32'h0);
    check("R10 reset released", 32'(coreReset), 32'h0);
    step(1'b1, 1'b0, 4'h8, 32'h4000_0000, "R10 ungate");
    check("R10 clock restored", 32'(coreClkEn), 32'h1);

    // R9 abort before hold completes
    cleanAll();
    step(1'b1, 1'b0, 4'h4, 32'h8000_0000, "R9 abort enter");
    idle(3, "R9 abort hold");
    step(1'b1, 1'b0, 4'h8, 32'h8000_0000, "R9 abort release");
    idle(2 * HOLD, "R9 abort wait");
    check("R9 no gate after abort", 32'(coreClkEn), 32'h1);

    // R11 single automatic set per entry
    cleanAll();
    step(1'b1, 1'b0, 4'h4, 32'h8000_0000, "R11 enter");
    idle(HOLD, "R11 hold");
    check("R11 gate set", 32'(coreClkEn), 32'h0);
    step(1'b1, 1'b0, 4'h8, 32'h4000_0000, "R11 ungate");
    idle(2 * HOLD, "R11 wait");
    check("R11 gate stays clear", 32'(coreClkEn), 32'h1);
    check("R11 reset still held", 32'(coreReset), 32'h1);

    // R12 collision of automatic set and software clear
    cleanAll();
    step(1'b1, 1'b0, 4'h4, 32'h8000_0000, "R12 enter");
    idle(HOLD - 1, "R12 hold");
    step(1'b1, 1'b0, 4'h8, 32'h4000_0000, "R12 collide");
    check("R12 hw set wins", 32'(coreClkEn), 32'h0);
    cleanAll();

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule